// File: doc/BRIEF.md
# Coprocessor Argument/Result DMA Sequencer

This block is the control front end of a compute coprocessor. Software or a DMA engine feeds it one or two operands through a single argument data port. Once the operand set is complete and the previous results have been fully read out, it fires a calculation on an internal fixed-latency core stub. It then presents one or two results through a single result data port. A control register selects the operand and result counts and holds three enables: a level interrupt, a DMA write channel and a DMA read channel. The two channels are independent of each other.

The two channels can run a buffer of calculations with no processor help. Each request line falls after the data access that serves it. A new calculation may only start once the last result of the previous one has been read, so the reader of the results sets the pace for both request lines. This holds even when that reader is an outside agent and not the DMA read channel. The core stub stands in for the arithmetic. It returns `a0 + a1` as the primary result and `a0 - a1` as the secondary result, both modulo 2^DATA_W.

Top module: `cpx_dma_seq`

## Requirements
- R1: Control word layout: bit0 interrupt enable, bit1 DMA write channel enable, bit2 DMA read channel enable, bit3 two operands (0 = one), bit4 two results (0 = one). `irq` is high exactly while interrupt enable is set and `res_ready` is high.
- R2: With the write channel enabled and the operand set not yet complete, `dma_wr_req` is high; it is low in the cycle after any argument write.
- R3: With two operands selected, a second write request follows the first operand write and the next write fills the secondary operand; with one operand selected, the secondary operand is taken as zero.
- R4: A calculation starts only when the operand set is complete, no calculation is running and all earlier results have been read. Pending results stay unchanged meanwhile. With nothing blocking it, `res_ready` rises at the eighth clock edge counting the edge that samples the completing argument write (core latency 6).
- R5: With the read channel enabled, `dma_rd_req` is high while `res_ready` is high, and is low in the cycle after any result read.
- R6: A valid result read returns its data one cycle after the strobe. The primary result comes first, then the secondary one if two results are selected. `res_ready` clears after the last selected result is read.
- R7: With only the write channel enabled, no read request appears. The next operand set is not requested until an outside reader has read the pending results.
- R8: Request lines come only from the enables and the data-port state. With both channels disabled no request appears, and clearing the write enable drops `dma_wr_req`.
- R9: A control register write returns both the operand and the result position to the primary slot.
- R10: A result read while `res_ready` is low leaves `res_rdata` and `res_ready` unchanged.
- R11: Argument writes made while a complete operand set is waiting to start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control word (layout in R1) |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | DATA_W | Argument value |
| res_rd | input | 1 | Result read strobe |
| res_rdata | output | DATA_W | Result data, valid the cycle after a read strobe |
| res_ready | output | 1 | Results are waiting to be read |
| irq | output | 1 | Level interrupt |
| dma_wr_req | output | 1 | DMA request for the next argument |
| dma_rd_req | output | 1 | DMA request for the next result |

## Verification
The collision that matters is an argument write that completes an operand set, landing in the same cycle as the read of the last pending result. The bench builds this on purpose: it reads the primary result, writes the first of two operands, and then raises the final read strobe and the completing write strobe on the same edge. It then checks that the final read returns the old secondary result and that the new calculation is not lost. It also counts the edges until `res_ready` returns and compares that count with the exact latency given in R4.

// File: rtl/cpx_seq_pkg.sv
package cpx_seq_pkg;

   localparam int CTRL_W  = 5;
   localparam int N_SLOTS = 2;

   typedef struct packed {
      logic res_two;
      logic arg_two;
      logic rd_chan;
      logic wr_chan;
      logic irq_en;
   } ctrl_t;

endpackage

// File: rtl/cpx_arg_collect.sv
module cpx_arg_collect
   import cpx_seq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             idx_clr,
   input  logic                             two_args,
   input  logic                             chan_en,
   input  logic                             wr,
   input  logic [DATA_W-1:0]                wdata,
   input  logic                             start,
   output logic                             full,
   output logic [N_SLOTS-1:0][DATA_W-1:0]   slots,
   output logic                             req
);

   logic idx_q;
   logic full_q;
   logic full_d;
   logic req_q;
   logic take;
   logic last_take;

   assign take      = wr && !full_q;
   assign last_take = take && (idx_q || !two_args);

   always_comb begin
      full_d = full_q;
      if (start)          full_d = 1'b0;
      else if (last_take) full_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= 1'b0;
         full_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         full_q <= full_d;
         if (idx_clr || last_take) idx_q <= 1'b0;
         else if (take)            idx_q <= 1'b1;
         req_q <= chan_en && !full_d && !wr;
      end
   end

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      logic [DATA_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          val_q <= '0;
         else if (take && (idx_q == 1'(g)))   val_q <= wdata;
         else if ((g != 0) && last_take)      val_q <= '0;
      end
      assign slots[g] = val_q;
   end

   assign full = full_q;
   assign req  = req_q;

endmodule

// File: rtl/cpx_core_stub.sv
module cpx_core_stub
   import cpx_seq_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LAT    = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start,
   input  logic [N_SLOTS-1:0][DATA_W-1:0]   ops,
   output logic                             busy,
   output logic                             done,
   output logic [N_SLOTS-1:0][DATA_W-1:0]   res
);

   logic              busy_q;
   logic [DATA_W-1:0] op_a;
   logic [DATA_W-1:0] op_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         op_a   <= '0;
         op_b   <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         op_a   <= ops[0];
         op_b   <= ops[1];
      end else if (done) begin
         busy_q <= 1'b0;
      end
   end

   if (LAT == 1) begin : g_single
      assign done = busy_q;
   end else begin : g_count
      localparam int CW = $clog2(LAT);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         cnt_q <= '0;
         else if (start)                     cnt_q <= CW'(LAT - 1);
         else if (busy_q && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
      end
      assign done = busy_q && (cnt_q == '0);
   end

   assign busy   = busy_q;
   assign res[0] = op_a + op_b;
   assign res[1] = op_a - op_b;

endmodule

// File: rtl/cpx_res_present.sv
module cpx_res_present
   import cpx_seq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             idx_clr,
   input  logic                             two_res,
   input  logic                             chan_en,
   input  logic                             load,
   input  logic [N_SLOTS-1:0][DATA_W-1:0]   res_in,
   input  logic                             rd,
   output logic                             ready,
   output logic [DATA_W-1:0]                rdata,
   output logic                             req
);

   logic                            ready_q;
   logic                            ready_d;
   logic                            idx_q;
   logic                            req_q;
   logic                            serve;
   logic                            last_serve;
   logic [DATA_W-1:0]               rdata_q;
   logic [N_SLOTS-1:0][DATA_W-1:0]  held;

   assign serve      = rd && ready_q;
   assign last_serve = serve && (idx_q || !two_res);

   always_comb begin
      ready_d = ready_q;
      if (load)            ready_d = 1'b1;
      else if (last_serve) ready_d = 1'b0;
   end

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_hold
      logic [DATA_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    val_q <= '0;
         else if (load) val_q <= res_in[g];
      end
      assign held[g] = val_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         idx_q   <= 1'b0;
         req_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ready_q <= ready_d;
         if (serve) rdata_q <= held[idx_q];
         if (idx_clr || load || last_serve) idx_q <= 1'b0;
         else if (serve)                    idx_q <= 1'b1;
         req_q <= chan_en && ready_d && !rd;
      end
   end

   assign ready = ready_q;
   assign rdata = rdata_q;
   assign req   = req_q;

endmodule

// File: rtl/cpx_dma_seq.sv
module cpx_dma_seq
   import cpx_seq_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CORE_LAT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [4:0]        ctl_wdata,
   input  logic              arg_wr,
   input  logic [DATA_W-1:0] arg_wdata,
   input  logic              res_rd,
   output logic [DATA_W-1:0] res_rdata,
   output logic              res_ready,
   output logic              irq,
   output logic              dma_wr_req,
   output logic              dma_rd_req
);

   if (DATA_W < 2) begin : g_bad_width
      $error("cpx_dma_seq: DATA_W must be at least 2");
   end
   if (CORE_LAT < 1) begin : g_bad_lat
      $error("cpx_dma_seq: CORE_LAT must be at least 1");
   end
   if (CTRL_W != 5) begin : g_bad_ctrl
      $error("cpx_dma_seq: control word width mismatch");
   end

   ctrl_t                           ctl_q;
   logic                            args_full;
   logic                            core_start;
   logic                            core_busy;
   logic                            core_done;
   logic [N_SLOTS-1:0][DATA_W-1:0]  arg_set;
   logic [N_SLOTS-1:0][DATA_W-1:0]  res_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctrl_t'(ctl_wdata);
   end

   assign core_start = args_full && !core_busy && !res_ready;

   cpx_arg_collect #(.DATA_W(DATA_W)) u_args (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_clr  (ctl_wr),
      .two_args (ctl_q.arg_two),
      .chan_en  (ctl_q.wr_chan),
      .wr       (arg_wr),
      .wdata    (arg_wdata),
      .start    (core_start),
      .full     (args_full),
      .slots    (arg_set),
      .req      (dma_wr_req)
   );

   cpx_core_stub #(.DATA_W(DATA_W), .LAT(CORE_LAT)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .start (core_start),
      .ops   (arg_set),
      .busy  (core_busy),
      .done  (core_done),
      .res   (res_set)
   );

   cpx_res_present #(.DATA_W(DATA_W)) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_clr (ctl_wr),
      .two_res (ctl_q.res_two),
      .chan_en (ctl_q.rd_chan),
      .load    (core_done),
      .res_in  (res_set),
      .rd      (res_rd),
      .ready   (res_ready),
      .rdata   (res_rdata),
      .req     (dma_rd_req)
   );

   assign irq = ctl_q.irq_en && res_ready;

endmodule

// File: rtl/cpx_dma_seq_chk.sv
module cpx_dma_seq_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arg_wr,
   input logic              res_rd,
   input logic              res_ready,
   input logic              irq,
   input logic              dma_wr_req,
   input logic              dma_rd_req,
   input logic [DATA_W-1:0] res_rdata,
   input logic              core_start,
   input logic              core_busy,
   input logic              core_done
);

   AST_IRQ_NEEDS_READY:  assert property (@(posedge clk) disable iff (!rst_n) irq |-> res_ready);                 // R1
   AST_WREQ_DROPS:       assert property (@(posedge clk) disable iff (!rst_n) arg_wr |=> !dma_wr_req);            // R2
   AST_START_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) core_start |=> !core_start);        // R4
   AST_START_BUSY:       assert property (@(posedge clk) disable iff (!rst_n) core_start |=> core_busy);          // R4
   AST_BUSY_NO_READY:    assert property (@(posedge clk) disable iff (!rst_n) core_busy |-> !res_ready);          // R4
   AST_RREQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n) dma_rd_req |-> res_ready);          // R5
   AST_RREQ_DROPS:       assert property (@(posedge clk) disable iff (!rst_n) res_rd |=> !dma_rd_req);            // R5
   AST_DONE_SETS_READY:  assert property (@(posedge clk) disable iff (!rst_n) core_done |=> res_ready);            // R6
   AST_IDLE_READ_HOLDS:  assert property (@(posedge clk) disable iff (!rst_n)
                                          (res_rd && !res_ready) |=> ($stable(res_rdata) && !res_ready));        // R10

endmodule

bind cpx_dma_seq cpx_dma_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arg_wr     (arg_wr),
   .res_rd     (res_rd),
   .res_ready  (res_ready),
   .irq        (irq),
   .dma_wr_req (dma_wr_req),
   .dma_rd_req (dma_rd_req),
   .res_rdata  (res_rdata),
   .core_start (core_start),
   .core_busy  (core_busy),
   .core_done  (core_done)
);

// File: tb/cpx_dma_seq_tb_top.sv
module cpx_dma_seq_tb_top;

   localparam int DW  = 16;
   localparam int LAT = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr = 1'b0;
   logic [4:0]    ctl_wdata = '0;
   logic          arg_wr = 1'b0;
   logic [DW-1:0] arg_wdata = '0;
   logic          res_rd = 1'b0;
   logic [DW-1:0] res_rdata;
   logic          res_ready;
   logic          irq;
   logic          dma_wr_req;
   logic          dma_rd_req;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   cpx_dma_seq #(.DATA_W(DW), .CORE_LAT(LAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .arg_wr(arg_wr), .arg_wdata(arg_wdata), .res_rd(res_rd), .res_rdata(res_rdata),
      .res_ready(res_ready), .irq(irq), .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req)
   );

   // {two operands, two results, operand0, operand1}
   localparam logic [33:0] VEC [0:5] = '{
      {1'b1, 1'b1, 16'd1000,  16'd24},
      {1'b0, 1'b0, 16'd77,    16'd500},
      {1'b1, 1'b0, 16'hFFFF,  16'd2},
      {1'b0, 1'b1, 16'd5,     16'd9},
      {1'b1, 1'b1, 16'd3,     16'd10},
      {1'b1, 1'b1, 16'h8000,  16'h8000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [4:0] v);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic arg_write(input logic [DW-1:0] v);
      @(negedge clk); arg_wr = 1'b1; arg_wdata = v;
      @(negedge clk); arg_wr = 1'b0;
      chk("R2 wreq low after write", 32'(dma_wr_req), 32'd0);
   endtask

   task automatic res_read(output logic [DW-1:0] v);
      @(negedge clk); res_rd = 1'b1;
      @(negedge clk); res_rd = 1'b0;
      v = res_rdata;
      chk("R5 rreq low after read", 32'(dma_rd_req), 32'd0);
   endtask

   function automatic logic pick(input int which);
      case (which)
         0:       return dma_wr_req;
         1:       return dma_rd_req;
         default: return res_ready;
      endcase
   endfunction

   task automatic wait_for(input int which, input string req);
      int n = 0;
      while (pick(which) !== 1'b1 && n < 200) begin
         @(negedge clk); n++;
      end
      chk(req, 32'(pick(which)), 32'd1);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [DW-1:0] v;
      logic [DW-1:0] prior;
      logic          seen;
      int            n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 reset ready", 32'(res_ready), 32'd0);
      chk("R1 reset irq", 32'(irq), 32'd0);
      chk("R2 reset wreq", 32'(dma_wr_req), 32'd0);
      chk("R5 reset rreq", 32'(dma_rd_req), 32'd0);
      chk("R10 reset rdata", 32'(res_rdata), 32'd0);

      // Table walk: both DMA channels and the interrupt enabled
      for (int i = 0; i < 6; i++) begin
         logic          two_a;
         logic          two_r;
         logic [DW-1:0] a0;
         logic [DW-1:0] a1;
         {two_a, two_r, a0, a1} = VEC[i];
         if (!two_a) a1 = '0;
         ctl_write({two_r, two_a, 1'b1, 1'b1, 1'b1});
         wait_for(0, "R2 wreq raised");
         arg_write(a0);
         if (two_a) begin
            wait_for(0, "R3 second wreq");
            arg_write(VEC[i][15:0]);
         end
         wait_for(1, "R5 rreq raised");
         chk("R1 irq with ready", 32'(irq), 32'd1);
         res_read(v);
         chk("R6 primary result", 32'(v), 32'(DW'(a0 + a1)));
         if (two_r) begin
            chk("R6 ready held for secondary", 32'(res_ready), 32'd1);
            wait_for(1, "R6 second rreq");
            res_read(v);
            chk("R3 R6 secondary result", 32'(v), 32'(DW'(a0 - a1)));
         end
         chk("R6 ready cleared", 32'(res_ready), 32'd0);
         chk("R1 irq cleared", 32'(irq), 32'd0);
      end

      // R10: idle read has no effect
      prior = res_rdata;
      res_read(v);
      chk("R10 idle read data", 32'(v), 32'(prior));
      chk("R10 idle read ready", 32'(res_ready), 32'd0);

      // R1 / R8: interrupt off, channels off
      ctl_write(5'b11000);
      arg_write(16'd6);
      arg_write(16'd2);
      wait_for(2, "R4 ready after start");
      chk("R1 irq masked", 32'(irq), 32'd0);
      chk("R8 no wreq when disabled", 32'(dma_wr_req), 32'd0);
      chk("R8 no rreq when disabled", 32'(dma_rd_req), 32'd0);
      ctl_write(5'b11001);
      chk("R1 irq after enable", 32'(irq), 32'd1);
      res_read(v); chk("R6 primary", 32'(v), 32'd8);
      res_read(v); chk("R6 secondary", 32'(v), 32'd4);
      chk("R1 irq off after reads", 32'(irq), 32'd0);

      // R4 / R11: restart gated by unread results; extra write ignored
      ctl_write(5'b11000);
      arg_write(16'd10);
      arg_write(16'd3);
      wait_for(2, "R4 ready");
      arg_write(16'd100);
      arg_write(16'd1);
      arg_write(16'd55);
      repeat (20) @(negedge clk);
      chk("R4 results still pending", 32'(res_ready), 32'd1);
      res_read(v); chk("R4 old primary kept", 32'(v), 32'd13);
      res_read(v); chk("R4 old secondary kept", 32'(v), 32'd7);
      wait_for(2, "R4 start after final read");
      res_read(v); chk("R11 primary ignores extra write", 32'(v), 32'd101);
      res_read(v); chk("R11 secondary ignores extra write", 32'(v), 32'd99);

      // R9: control write returns the operand position to primary
      arg_write(16'd7);
      ctl_write(5'b11000);
      arg_write(16'd20);
      arg_write(16'd4);
      wait_for(2, "R9 ready");
      res_read(v); chk("R9 primary", 32'(v), 32'd24);
      res_read(v); chk("R9 secondary", 32'(v), 32'd16);

      // R7: write channel only, outside reader paces
      ctl_write(5'b11010);
      wait_for(0, "R7 wreq");
      arg_write(16'd9);
      wait_for(0, "R3 second wreq");
      arg_write(16'd4);
      seen = 1'b0;
      n = 0;
      while (res_ready !== 1'b1 && n < 50) begin
         @(negedge clk); n++;
         if (dma_rd_req) seen = 1'b1;
      end
      chk("R7 no rreq", 32'(seen), 32'd0);
      wait_for(0, "R7 wreq after start");
      arg_write(16'd1);
      wait_for(0, "R7 second wreq");
      arg_write(16'd1);
      repeat (15) @(negedge clk);
      chk("R7 wreq held by unread results", 32'(dma_wr_req), 32'd0);
      res_read(v); chk("R7 primary", 32'(v), 32'd13);
      res_read(v); chk("R7 secondary", 32'(v), 32'd5);
      wait_for(0, "R7 wreq after reader");
      wait_for(2, "R7 ready");
      res_read(v); chk("R7 next primary", 32'(v), 32'd2);
      res_read(v); chk("R7 next secondary", 32'(v), 32'd0);
      ctl_write(5'b11000);
      @(negedge clk);
      chk("R8 wreq drops on disable", 32'(dma_wr_req), 32'd0);

      // R4: completing write and final read in the same cycle
      arg_write(16'd2);
      arg_write(16'd1);
      wait_for(2, "R4 ready");
      res_read(v); chk("R6 primary", 32'(v), 32'd3);
      arg_write(16'd8);
      @(negedge clk); res_rd = 1'b1; arg_wr = 1'b1; arg_wdata = 16'd5;
      @(negedge clk); res_rd = 1'b0; arg_wr = 1'b0;
      chk("R4 final read in collision", 32'(res_rdata), 32'd1);
      n = 0;
      while (res_ready !== 1'b1 && n < 50) begin
         @(negedge clk); n++;
      end
      chk("R4 latency after collision", 32'(n), 32'(LAT + 1));
      res_read(v); chk("R4 collision primary", 32'(v), 32'd13);
      res_read(v); chk("R4 collision secondary", 32'(v), 32'd3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule